// File: doc/BRIEF.md
# Dual-Read Cache Data Array Slice

This block models one slice of a level-one data cache array that serves two independent read requests or one write in each clock cycle. The stored data is organised as rows of eight bytes per way. A write fills one row of one way under per-byte enables. A read port addresses half a row and returns four bytes from every way at once. The wanted way is picked only at the last pipeline stage, from a one-hot set select that arrives one cycle after the address. This lets the set prediction resolve in parallel with the array access.

The access takes two register stages. The first stage holds the per-way words taken from the array, or the write data when it is looped back. The second stage is the output latch. It rests at all ones and keeps only the bits that every selected way agrees on. During a write, the read outputs carry the write data, split between the two ports by a steering input. A wordline-disable input keeps the array untouched and uses the same loop-back path, so the output path can be exercised with no array access and no extra latency.

Top module: `dcache_dual_rd_array`

## Requirements
- R1: A write has priority over reads. In a cycle with `wr_en` high, neither read request reaches the array, and both ports report the write data of R4 instead of stored contents.
- R2: A read on a port in cycle N uses `rd_addr` bits [8:1] as the row and bit 0 as the half (0 = row bytes 3..0, 1 = row bytes 7..4). The port's set select is applied in cycle N+1, and the result appears in cycle N+2 with the port's valid high.
- R3: A write stores into row `wr_row` of way `wr_way`. `wr_be` bit i enables byte i (`wr_data` bits 8i+7..8i), and bytes whose enable is low keep their old contents.
- R4: In a write cycle, both ports become valid two cycles later with pass-through data, whatever the byte enables. With `wr_steer`=0, port A carries `wr_data[31:0]` and port B carries `wr_data[63:32]`. With `wr_steer`=1 the two halves are swapped.
- R5: While `wl_dis` is high, no row is written, even with `wr_en` high. Both ports deliver the steered write data of R4 with the same two-cycle latency.
- R6: The output word is the bitwise AND of the words of all ways whose select bit is set. A one-hot select returns exactly that way's word. An all-zero select returns all ones.
- R7: `sel_err` of a port is high together with a valid result whose set select had more than one bit set, and it is low otherwise.
- R8: A read of the row being written in the same cycle returns the pass-through write data. A later read of that row returns the newly stored bytes.
- R9: After reset, and two cycles after a cycle in which a port has no request, no write and no wordline disable, that port shows valid low, all-ones data and no error.
- R10: The two read ports are independent: they may address different rows and halves and use different set selects in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline state |
| rd_en_a | input | 1 | Read request, port A |
| rd_addr_a | input | 9 | Row (bits 8:1) and half (bit 0), port A |
| rd_en_b | input | 1 | Read request, port B |
| rd_addr_b | input | 9 | Row (bits 8:1) and half (bit 0), port B |
| wr_en | input | 1 | Write request |
| wr_row | input | 8 | Row written |
| wr_way | input | 3 | Way written (binary index) |
| wr_be | input | 8 | Byte enables of the write |
| wr_data | input | 64 | Write data |
| wr_steer | input | 1 | Swaps which port gets the upper half of the pass-through data |
| wl_dis | input | 1 | Wordline disable: array untouched, output path in loop-back |
| sel_a | input | 8 | One-hot late set select, port A, applied one cycle after the address |
| sel_b | input | 8 | One-hot late set select, port B |
| dout_a | output | 32 | Output latch, port A |
| dout_b | output | 32 | Output latch, port B |
| vld_a | output | 1 | Port A result valid |
| vld_b | output | 1 | Port B result valid |
| sel_err_a | output | 1 | Port A set select had several bits set |
| sel_err_b | output | 1 | Port B set select had several bits set |

## Verification
The whole array is first filled through the write port, and every fill write doubles as a pass-through check with the steering alternating. A read sweep then covers every half-row on port A while port B walks the addresses in reverse with a different way. This shows up swapped halves, crossed ports and a misdecoded row or way. All 256 byte-enable patterns are written into one row and read back. This separates per-byte masking from whole-half writes. Directed cases then cover a write colliding with a read of the same row, wordline disable with and without a write, zero and multi-bit set selects (the AND merge and the error flag), and an idle port next to an active one.

// File: rtl/cda_pkg.sv
package cda_pkg;
  // Number of read ports of the slice; the structure is generated per port.
  localparam int unsigned NPORTS = 2;

  // Count of set bits above one means a conflicting late select.
  function automatic logic multi_hot(input logic [31:0] v);
    return $countones(v) > 1;
  endfunction
endpackage

// File: rtl/cda_ctrl.sv
module cda_ctrl #(
  parameter int unsigned HALF_W = 32
) (
  input  logic                  rd_en_a,
  input  logic                  rd_en_b,
  input  logic                  wr_en,
  input  logic                  wl_dis,
  input  logic                  wr_steer,
  input  logic [2*HALF_W-1:0]   wr_data,
  output logic                  mem_we,
  output logic                  fetch_a,
  output logic                  fetch_b,
  output logic                  loop_back,
  output logic [HALF_W-1:0]     pass_a,
  output logic [HALF_W-1:0]     pass_b
);
  // Half of the write word routed to a port; steer swaps the halves.
  function automatic logic [HALF_W-1:0] steer_half(
    input logic [2*HALF_W-1:0] d, input logic st, input logic port_b);
    return (st ^ port_b) ? d[2*HALF_W-1:HALF_W] : d[HALF_W-1:0];
  endfunction

  // Write wins the cycle; wordline disable blocks all array access.
  assign mem_we    = wr_en & ~wl_dis;
  assign fetch_a   = rd_en_a & ~wr_en & ~wl_dis;
  assign fetch_b   = rd_en_b & ~wr_en & ~wl_dis;
  assign loop_back = wr_en | wl_dis;
  assign pass_a    = steer_half(wr_data, wr_steer, 1'b0);
  assign pass_b    = steer_half(wr_data, wr_steer, 1'b1);

  always_comb begin
    a_single_op_r1 : assert (!(mem_we && (fetch_a || fetch_b)));
  end
endmodule

// File: rtl/cda_store.sv
module cda_store #(
  parameter int unsigned ROWS  = 256,
  parameter int unsigned WAYS  = 8,
  parameter int unsigned ROW_W = 64,
  localparam int unsigned RAW  = $clog2(ROWS),
  localparam int unsigned WYW  = $clog2(WAYS),
  localparam int unsigned BE_W = ROW_W / 8
) (
  input  logic                        clk,
  input  logic                        we,
  input  logic [RAW-1:0]              wrow,
  input  logic [WYW-1:0]              wway,
  input  logic [BE_W-1:0]             be,
  input  logic [ROW_W-1:0]            wdata,
  input  logic [RAW-1:0]              row_a,
  input  logic [RAW-1:0]              row_b,
  output logic [WAYS-1:0][ROW_W-1:0]  words_a,
  output logic [WAYS-1:0][ROW_W-1:0]  words_b
);
  logic [ROW_W-1:0] mem [ROWS][WAYS];

  // Byte-granular write; contents are not reset.
  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < BE_W; b++) begin
        if (be[b]) mem[wrow][wway][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end

  // Both port decoders read every way of their row.
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign words_a[w] = mem[row_a][w];
    assign words_b[w] = mem[row_b][w];
  end
endmodule

// File: rtl/cda_port.sv
module cda_port #(
  parameter int unsigned WAYS   = 8,
  parameter int unsigned HALF_W = 32,
  localparam int unsigned ROW_W = 2 * HALF_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_fetch,
  input  logic                        req_pass,
  input  logic                        half,
  input  logic [WAYS-1:0][ROW_W-1:0]  row_words,
  input  logic [HALF_W-1:0]           pass_word,
  input  logic [WAYS-1:0]             sel,
  output logic [HALF_W-1:0]           dout,
  output logic                        vld,
  output logic                        err
);
  import cda_pkg::*;

  function automatic logic [HALF_W-1:0] pick_half(
    input logic [ROW_W-1:0] r, input logic h);
    return h ? r[ROW_W-1:HALF_W] : r[HALF_W-1:0];
  endfunction

  // Output latch model: starts at all ones, each selected way can pull bits low.
  function automatic logic [HALF_W-1:0] late_and(
    input logic [WAYS-1:0][HALF_W-1:0] wd, input logic [WAYS-1:0] s);
    logic [HALF_W-1:0] acc;
    acc = '1;
    for (int w = 0; w < WAYS; w++) begin
      if (s[w]) acc = acc & wd[w];
    end
    return acc;
  endfunction

  logic                          s1_vld;
  logic [WAYS-1:0][HALF_W-1:0]   s1_word;
  logic                          s1_load;
  logic [31:0]                   sel_ext;

  assign s1_load = req_fetch | req_pass;
  assign sel_ext = 32'(sel);

  // Stage 1: per-way words from the array, or looped-back write data.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_vld <= 1'b0;
    else        s1_vld <= s1_load;
  end

  always_ff @(posedge clk) begin
    if (s1_load) begin
      for (int w = 0; w < WAYS; w++) begin
        s1_word[w] <= req_pass ? pass_word : pick_half(row_words[w], half);
      end
    end
  end

  // Stage 2: late-select output latch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      dout <= '1;
      err  <= 1'b0;
    end else begin
      vld  <= s1_vld;
      dout <= s1_vld ? late_and(s1_word, sel) : '1;
      err  <= s1_vld & multi_hot(sel_ext);
    end
  end

  p_idle_ones_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    !vld |-> (dout == '1 && !err));
  p_zero_sel_ones_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (vld && $past(sel) == '0) |-> dout == '1);
  p_err_multi_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> (err == ($countones($past(sel)) > 1)));
  p_vld_origin_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> $past(req_fetch || req_pass, 2));
endmodule

// File: rtl/dcache_dual_rd_array.sv
module dcache_dual_rd_array #(
  parameter int unsigned ROWS   = 256,
  parameter int unsigned WAYS   = 8,
  parameter int unsigned HALF_W = 32,
  localparam int unsigned ROW_W = 2 * HALF_W,
  localparam int unsigned RAW   = $clog2(ROWS),
  localparam int unsigned ADW   = RAW + 1,
  localparam int unsigned WYW   = $clog2(WAYS),
  localparam int unsigned BE_W  = ROW_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en_a,
  input  logic [ADW-1:0]    rd_addr_a,
  input  logic              rd_en_b,
  input  logic [ADW-1:0]    rd_addr_b,
  input  logic              wr_en,
  input  logic [RAW-1:0]    wr_row,
  input  logic [WYW-1:0]    wr_way,
  input  logic [BE_W-1:0]   wr_be,
  input  logic [ROW_W-1:0]  wr_data,
  input  logic              wr_steer,
  input  logic              wl_dis,
  input  logic [WAYS-1:0]   sel_a,
  input  logic [WAYS-1:0]   sel_b,
  output logic [HALF_W-1:0] dout_a,
  output logic [HALF_W-1:0] dout_b,
  output logic              vld_a,
  output logic              vld_b,
  output logic              sel_err_a,
  output logic              sel_err_b
);
  import cda_pkg::*;

  logic mem_we, fetch_a, fetch_b, loop_back;
  logic [HALF_W-1:0] pass_a, pass_b;
  logic [WAYS-1:0][ROW_W-1:0] words_a, words_b;

  cda_ctrl #(.HALF_W(HALF_W)) ctrl_i (
    .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .wr_en(wr_en), .wl_dis(wl_dis),
    .wr_steer(wr_steer), .wr_data(wr_data), .mem_we(mem_we),
    .fetch_a(fetch_a), .fetch_b(fetch_b), .loop_back(loop_back),
    .pass_a(pass_a), .pass_b(pass_b));

  cda_store #(.ROWS(ROWS), .WAYS(WAYS), .ROW_W(ROW_W)) store_i (
    .clk(clk), .we(mem_we), .wrow(wr_row), .wway(wr_way), .be(wr_be),
    .wdata(wr_data), .row_a(rd_addr_a[ADW-1:1]), .row_b(rd_addr_b[ADW-1:1]),
    .words_a(words_a), .words_b(words_b));

  // Per-port views so the output stage can be generated.
  logic                       p_fetch [NPORTS];
  logic                       p_half  [NPORTS];
  logic [WAYS-1:0][ROW_W-1:0] p_words [NPORTS];
  logic [HALF_W-1:0]          p_pass  [NPORTS];
  logic [WAYS-1:0]            p_sel   [NPORTS];
  logic [HALF_W-1:0]          p_dout  [NPORTS];
  logic                       p_vld   [NPORTS];
  logic                       p_err   [NPORTS];

  assign p_fetch[0] = fetch_a;       assign p_fetch[1] = fetch_b;
  assign p_half[0]  = rd_addr_a[0];  assign p_half[1]  = rd_addr_b[0];
  assign p_words[0] = words_a;       assign p_words[1] = words_b;
  assign p_pass[0]  = pass_a;        assign p_pass[1]  = pass_b;
  assign p_sel[0]   = sel_a;         assign p_sel[1]   = sel_b;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    cda_port #(.WAYS(WAYS), .HALF_W(HALF_W)) port_i (
      .clk(clk), .rst_n(rst_n), .req_fetch(p_fetch[p]), .req_pass(loop_back),
      .half(p_half[p]), .row_words(p_words[p]), .pass_word(p_pass[p]),
      .sel(p_sel[p]), .dout(p_dout[p]), .vld(p_vld[p]), .err(p_err[p]));
  end

  assign dout_a = p_dout[0];  assign dout_b = p_dout[1];
  assign vld_a  = p_vld[0];   assign vld_b  = p_vld[1];
  assign sel_err_a = p_err[0]; assign sel_err_b = p_err[1];

  p_wldis_blocks_write_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    wl_dis |-> !mem_we);
  p_write_valid_both_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(wr_en, 2)) |-> (vld_a && vld_b));
endmodule

// File: tb/dcache_dual_rd_array_tb.sv
module dcache_dual_rd_array_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_en_a = 0, rd_en_b = 0, wr_en = 0, wr_steer = 0, wl_dis = 0;
  logic [8:0] rd_addr_a = 0, rd_addr_b = 0;
  logic [7:0] wr_row = 0, wr_be = 0, sel_a = 0, sel_b = 0;
  logic [2:0] wr_way = 0;
  logic [63:0] wr_data = 0;
  logic [31:0] dout_a, dout_b;
  logic vld_a, vld_b, sel_err_a, sel_err_b;

  int vectors = 0;
  int fails = 0;
  logic [63:0] model [256][8];

  always #10 clk = ~clk;

  dcache_dual_rd_array dut_i (
    .clk(clk), .rst_n(rst_n), .rd_en_a(rd_en_a), .rd_addr_a(rd_addr_a),
    .rd_en_b(rd_en_b), .rd_addr_b(rd_addr_b), .wr_en(wr_en), .wr_row(wr_row),
    .wr_way(wr_way), .wr_be(wr_be), .wr_data(wr_data), .wr_steer(wr_steer),
    .wl_dis(wl_dis), .sel_a(sel_a), .sel_b(sel_b), .dout_a(dout_a),
    .dout_b(dout_b), .vld_a(vld_a), .vld_b(vld_b), .sel_err_a(sel_err_a),
    .sel_err_b(sel_err_b));

  function automatic logic [63:0] pattern(input int r, input int w);
    return {8'(r), 8'(w), 8'(r + w), 8'(r * 3), 8'(~r), 8'(w * 17),
            8'(r ^ 8'h5a), 8'(r + (w << 4))};
  endfunction

  // Expected read result: AND of the selected ways' halves, ones if none.
  function automatic logic [31:0] rd_exp(input logic [8:0] a, input logic [7:0] s);
    logic [31:0] acc;
    logic [63:0] r;
    acc = 32'hffff_ffff;
    for (int w = 0; w < 8; w++) begin
      r = model[a[8:1]][w];
      if (s[w]) acc = acc & (a[0] ? r[63:32] : r[31:0]);
    end
    return acc;
  endfunction

  function automatic logic [31:0] pass_exp(input logic [63:0] d, input logic st,
                                           input logic pb, input logic [7:0] s);
    if (s == 8'h00) return 32'hffff_ffff;
    return (st ^ pb) ? d[63:32] : d[31:0];
  endfunction

  function automatic logic multi(input logic [7:0] s);
    return $countones(s) > 1;
  endfunction

  task automatic check(input string req, input logic [31:0] ga, input logic [31:0] ea,
                       input logic [31:0] gb, input logic [31:0] eb,
                       input logic [3:0] gf, input logic [3:0] ef);
    vectors++;
    if (ga !== ea || gb !== eb || gf !== ef) begin
      fails++;
      $display("FAIL %s: a=%h b=%h flags=%b expected a=%h b=%h flags=%b",
               req, ga, gb, gf, ea, eb, ef);
    end
  endtask

  // One isolated operation: drive in cycle N, select in N+1, sample in N+2.
  task automatic do_op(input logic rea, input logic [8:0] aa, input logic reb,
                       input logic [8:0] ab, input logic we, input logic [7:0] row,
                       input logic [2:0] way, input logic [7:0] be,
                       input logic [63:0] d, input logic st, input logic wd,
                       input logic [7:0] sa, input logic [7:0] sb,
                       input logic [31:0] ea, input logic [31:0] eb,
                       input logic [3:0] ef, input string req);
    @(negedge clk);
    rd_en_a = rea; rd_addr_a = aa; rd_en_b = reb; rd_addr_b = ab;
    wr_en = we; wr_row = row; wr_way = way; wr_be = be; wr_data = d;
    wr_steer = st; wl_dis = wd; sel_a = 8'h00; sel_b = 8'h00;
    @(negedge clk);
    rd_en_a = 0; rd_en_b = 0; wr_en = 0; wl_dis = 0; sel_a = sa; sel_b = sb;
    @(negedge clk);
    check(req, dout_a, ea, dout_b, eb, {vld_a, vld_b, sel_err_a, sel_err_b}, ef);
    sel_a = 8'h00; sel_b = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [7:0] sa, sb;
    logic [8:0] aa, ab;
    repeat (3) @(negedge clk);
    check("R9 reset", dout_a, 32'hffff_ffff, dout_b, 32'hffff_ffff, {vld_a, vld_b, sel_err_a, sel_err_b}, 4'b0000);
    rst_n = 1'b1;

    // Fill every row and way; each write checks pass-through steering (R4).
    for (int r = 0; r < 256; r++) begin
      for (int w = 0; w < 8; w++) begin
        d = pattern(r, w);
        sa = 8'(1 << w); sb = 8'(1 << ((w + 1) % 8));
        do_op(0, 0, 0, 0, 1, 8'(r), 3'(w), 8'hff, d, 1'(r ^ w), 0, sa, sb,
              pass_exp(d, 1'(r ^ w), 0, sa), pass_exp(d, 1'(r ^ w), 1, sb), 4'b1100, "R4 pass-through");
        model[r][w] = d;
      end
    end

    // Read sweep on both ports with differing addresses and ways (R2, R10).
    for (int i = 0; i < 512; i++) begin
      for (int k = 0; k < 8; k++) begin
        aa = 9'(i); ab = 9'(511 - i);
        sa = 8'(1 << k); sb = 8'(1 << ((k + 3) % 8));
        do_op(1, aa, 1, ab, 0, 0, 0, 0, 0, 0, 0, sa, sb,
              rd_exp(aa, sa), rd_exp(ab, sb), 4'b1100, "R2 R10 read sweep");
      end
    end

    // Every byte-enable pattern on row 9 way 2, read back both halves (R3).
    for (int be = 0; be < 256; be++) begin
      d = 64'h0123_4567_89ab_cdef ^ {8{8'(be)}};
      do_op(0, 0, 0, 0, 1, 8'd9, 3'd2, 8'(be), d, 0, 0, 8'h04, 8'h04,
            d[31:0], d[63:32], 4'b1100, "R3 write cycle");
      for (int b = 0; b < 8; b++) begin
        if (be[b]) model[9][2][8*b +: 8] = d[8*b +: 8];
      end
      do_op(1, {8'd9, 1'b0}, 1, {8'd9, 1'b1}, 0, 0, 0, 0, 0, 0, 0, 8'h04, 8'h04,
            rd_exp({8'd9, 1'b0}, 8'h04), rd_exp({8'd9, 1'b1}, 8'h04), 4'b1100, "R3 byte enables");
    end

    // Wordline disable with a write: loop-back only, row unchanged (R5).
    d = 64'hdead_beef_cafe_f00d;
    do_op(0, 0, 0, 0, 1, 8'd20, 3'd4, 8'hff, d, 1, 1, 8'h10, 8'h01,
          d[63:32], d[31:0], 4'b1100, "R5 disable with write");
    do_op(1, {8'd20, 1'b0}, 1, {8'd20, 1'b1}, 0, 0, 0, 0, 0, 0, 0, 8'h10, 8'h10,
          rd_exp({8'd20, 1'b0}, 8'h10), rd_exp({8'd20, 1'b1}, 8'h10), 4'b1100, "R5 row untouched");
    do_op(1, {8'd21, 1'b0}, 0, 0, 0, 0, 0, 0, 64'h1111_2222_3333_4444, 0, 1, 8'h02, 8'h08,
          32'h3333_4444, 32'h1111_2222, 4'b1100, "R5 disable without write");

    // Same-row read and write in one cycle (R1, R8).
    d = 64'h5555_aaaa_0f0f_f0f0;
    do_op(1, {8'd30, 1'b0}, 1, {8'd100, 1'b1}, 1, 8'd30, 3'd0, 8'hff, d, 0, 0, 8'h01, 8'h01,
          d[31:0], d[63:32], 4'b1100, "R1 R8 write wins");
    model[30][0] = d;
    do_op(1, {8'd30, 1'b0}, 1, {8'd30, 1'b1}, 0, 0, 0, 0, 0, 0, 0, 8'h01, 8'h01,
          d[31:0], d[63:32], 4'b1100, "R8 new data stored");

    // Zero and multi-bit late selects (R6, R7).
    for (int t = 0; t < 6; t++) begin
      case (t)
        0: sa = 8'h00; 1: sa = 8'h03; 2: sa = 8'hff;
        3: sa = 8'h81; 4: sa = 8'h10; default: sa = 8'h5a;
      endcase
      sb = ~sa;
      do_op(1, {8'd7, 1'b1}, 1, {8'd200, 1'b0}, 0, 0, 0, 0, 0, 0, 0, sa, sb,
            rd_exp({8'd7, 1'b1}, sa), rd_exp({8'd200, 1'b0}, sb),
            {2'b11, multi(sa), multi(sb)}, "R6 R7 late select");
    end

    // Idle port beside an active one (R9).
    do_op(1, {8'd55, 1'b1}, 0, {8'd56, 1'b0}, 0, 0, 0, 0, 0, 0, 0, 8'h20, 8'h20,
          rd_exp({8'd55, 1'b1}, 8'h20), 32'hffff_ffff, 4'b1000, "R9 idle port");
    do_op(0, 0, 1, {8'd57, 1'b0}, 0, 0, 0, 0, 0, 0, 0, 8'h06, 8'h40,
          32'hffff_ffff, rd_exp({8'd57, 1'b0}, 8'h40), 4'b0100, "R9 idle port A");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule